// File: doc/BRIEF.md
# Fully-Associative Cache Tag Unit

This block holds the tag and valid bit of every line in a small fully-associative cache. It compares the incoming line address against all stored tags at once, and it reports hit, miss and the index of the matching line combinationally in the same cycle. The data array sits outside the block and is addressed with that index.

A command is decoded from four inputs: a lookup strobe, a write flag, a drop (invalidate) flag and a fill strobe. Each command completes in one clock cycle. Recency state and tag contents change only on the rising clock edge. The block keeps a least-recently-used order over the lines. From that order it always shows which line the next fill will overwrite, together with the tag currently held there. This lets the refill logic write back or discard the old line before it issues the fill.

Top module: `tag_unit_fa`

## Requirements
- R1: Synchronous reset clears every valid bit and every tag to zero. It sets the recency order so that line 0 is least recent and line LINES-1 is most recent. After reset the victim index is 0.
- R2: Hit and miss are both low while `cmd_req` is low. While `cmd_req` is high, exactly one of them is high, and both follow `addr` combinationally in the same cycle.
- R3: A hit means some valid line holds a tag equal to `addr`, and `hit_line` gives the lowest such line index. If no valid line matches, the result is a miss.
- R4: A read hit (`cmd_req`=1, `cmd_wr`=0, `cmd_inval`=0) or an update hit (`cmd_wr`=1) makes the hit line most recently used at the next rising edge. Its tag and valid bit are left unchanged.
- R5: A lookup with `cmd_inval`=1 that hits clears that line's valid bit at the next edge and makes the line least recently used, so it becomes the next victim.
- R6: A miss changes no tag, valid bit or recency state, whether or not `cmd_inval` or `cmd_wr` is set.
- R7: `victim_line` is the least recently used invalid line when any line is invalid, and otherwise the least recently used line. `victim_tag` is the tag stored at `victim_line`.
- R8: A fill (`cmd_fill`=1 with `cmd_req`=0) writes `addr` as the tag of the victim line, sets the line valid and makes it most recently used at the next edge.
- R9: All four command inputs low is a no-operation. `cmd_req` and `cmd_fill` must not be high together; if they are, the lookup takes effect and the fill is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_req | input | 1 | Lookup strobe |
| cmd_wr | input | 1 | Lookup is an update (write) access |
| cmd_inval | input | 1 | Drop the line after a hitting lookup |
| cmd_fill | input | 1 | Store `addr` into the victim line |
| addr | input | AW | Line address used for lookup and fill |
| hit | output | 1 | Lookup found a valid matching line |
| miss | output | 1 | Lookup found no valid matching line |
| hit_line | output | LW | Index of the matching line |
| victim_line | output | LW | Line the next fill will overwrite |
| victim_tag | output | AW | Tag currently stored at `victim_line` |

## Verification
Hit, miss and `hit_line` respond in the same cycle as the address and command, with no register in between. The bench therefore drives each command just after a falling edge and samples those outputs two nanoseconds later, before the rising edge. State changes from R4, R5 and R8 become visible one edge later, through `victim_line` and `victim_tag` and through the outcome of the next lookup. These are sampled in the following cycle's window. An independent timestamp model gives the expected victim: each line carries a last-use number, a hit raises it above all others and a drop lowers it below all others.

// File: rtl/tagu_pkg.sv
package tagu_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_UPDATE,
    OP_READ_DROP,
    OP_WRITE_DROP,
    OP_FILL
  } tagu_op_e;

  // lookup has priority over fill when both are (illegally) raised
  function automatic tagu_op_e decode_op(input logic req, input logic wr,
                                         input logic inv, input logic fill);
    if (req) begin
      if (inv) return wr ? OP_WRITE_DROP : OP_READ_DROP;
      return wr ? OP_UPDATE : OP_READ;
    end
    if (fill) return OP_FILL;
    return OP_NONE;
  endfunction

  function automatic logic is_drop(input tagu_op_e op);
    return (op == OP_READ_DROP) || (op == OP_WRITE_DROP);
  endfunction

  function automatic logic is_keep(input tagu_op_e op);
    return (op == OP_READ) || (op == OP_UPDATE);
  endfunction

endpackage

// File: rtl/tagu_store.sv
module tagu_store #(
  parameter int LINES = 32,
  parameter int AW    = 8,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_line,
  input  logic             clr_en,
  input  logic [LW-1:0]    clr_line,
  input  logic [LW-1:0]    rd_line,
  output logic [AW-1:0]    rd_tag,
  output logic [LINES-1:0] match_vec,
  output logic [LINES-1:0] valid_vec
);

  logic [AW-1:0]    tag_q [LINES];
  logic [LINES-1:0] valid_q;

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      assign match_vec[gi] = valid_q[gi] && (tag_q[gi] == addr);

      always_ff @(posedge clk) begin
        if (rst) begin
          tag_q[gi]   <= '0;
          valid_q[gi] <= 1'b0;
        end else if (wr_en && (wr_line == LW'(gi))) begin
          tag_q[gi]   <= addr;
          valid_q[gi] <= 1'b1;
        end else if (clr_en && (clr_line == LW'(gi))) begin
          valid_q[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  assign valid_vec = valid_q;
  assign rd_tag    = tag_q[rd_line];

  // R8: a written line is valid and holds the written tag one edge later
  a_r8_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_line)] && (tag_q[$past(wr_line)] == $past(addr)));

  // R5: a cleared line is invalid one edge later
  a_r5_drop_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !wr_en) |=> !valid_q[$past(clr_line)]);

  // R1: reset leaves nothing valid
  a_r1_reset_invalid: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0));

endmodule

// File: rtl/tagu_lru.sv
module tagu_lru #(
  parameter int LINES = 32,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_mru,
  input  logic             touch_lru,
  input  logic [LW-1:0]    touch_line,
  input  logic [LINES-1:0] valid_vec,
  output logic [LW-1:0]    victim_line
);

  // ord_q[0] is least recent, ord_q[LINES-1] most recent
  logic [LW-1:0]    ord_q [LINES];
  logic [LW-1:0]    ord_d [LINES];
  logic [LW-1:0]    touch_pos;
  logic [LINES-1:0] seen;
  logic             inv_found;
  logic [LW-1:0]    inv_pick;

  always_comb begin
    touch_pos = '0;
    for (int p = 0; p < LINES; p++)
      if (ord_q[p] == touch_line) touch_pos = LW'(p);
  end

  always_comb begin
    for (int q = 0; q < LINES; q++) ord_d[q] = ord_q[q];
    if (touch_mru) begin
      for (int q = 0; q < LINES - 1; q++)
        if (LW'(q) >= touch_pos) ord_d[q] = ord_q[q+1];
      ord_d[LINES-1] = touch_line;
    end else if (touch_lru) begin
      for (int q = 1; q < LINES; q++)
        if (LW'(q) <= touch_pos) ord_d[q] = ord_q[q-1];
      ord_d[0] = touch_line;
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < LINES; q++) begin
      if (rst) ord_q[q] <= LW'(q);
      else     ord_q[q] <= ord_d[q];
    end
  end

  // least recent invalid line wins; otherwise the head of the order
  always_comb begin
    inv_found = 1'b0;
    inv_pick  = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (!valid_vec[ord_q[p]]) begin
        inv_found = 1'b1;
        inv_pick  = ord_q[p];
      end
    end
  end

  assign victim_line = inv_found ? inv_pick : ord_q[0];

  always_comb begin
    seen = '0;
    for (int p = 0; p < LINES; p++) seen[ord_q[p]] = 1'b1;
  end

  // R4 R8: touched line becomes most recent
  a_r4_mru_tail: assert property (@(posedge clk) disable iff (rst)
    touch_mru |=> ord_q[LINES-1] == $past(touch_line));

  // R5: dropped line becomes least recent
  a_r5_lru_head: assert property (@(posedge clk) disable iff (rst)
    (touch_lru && !touch_mru) |=> ord_q[0] == $past(touch_line));

  // R7: the order stays a permutation of all lines
  a_r7_order_perm: assert property (@(posedge clk) disable iff (rst)
    &seen);

  // R1: line 0 is first victim after reset
  a_r1_reset_victim: assert property (@(posedge clk)
    $past(rst) |-> (victim_line == '0));

endmodule

// File: rtl/tag_unit_fa.sv
module tag_unit_fa
  import tagu_pkg::*;
#(
  parameter int LINES = 32,
  parameter int AW    = 8,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_req,
  input  logic          cmd_wr,
  input  logic          cmd_inval,
  input  logic          cmd_fill,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          miss,
  output logic [LW-1:0] hit_line,
  output logic [LW-1:0] victim_line,
  output logic [AW-1:0] victim_tag
);

  function automatic logic [LW-1:0] lowest_set(input logic [LINES-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = LW'(i);
    return r;
  endfunction

  tagu_op_e         op;
  logic [LINES-1:0] match_vec;
  logic [LINES-1:0] valid_vec;
  logic             any_match;
  logic             ev_keep_hit;
  logic             ev_drop_hit;
  logic             ev_fill;
  logic             touch_mru;
  logic [LW-1:0]    touch_line;

  assign op          = decode_op(cmd_req, cmd_wr, cmd_inval, cmd_fill);
  assign any_match   = |match_vec;
  assign hit         = cmd_req && any_match;
  assign miss        = cmd_req && !any_match;
  assign hit_line    = lowest_set(match_vec);

  assign ev_keep_hit = is_keep(op) && any_match;
  assign ev_drop_hit = is_drop(op) && any_match;
  assign ev_fill     = (op == OP_FILL);
  assign touch_mru   = ev_keep_hit || ev_fill;
  assign touch_line  = ev_fill ? victim_line : hit_line;

  tagu_store #(.LINES(LINES), .AW(AW)) i_store (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (ev_fill),
    .wr_line   (victim_line),
    .clr_en    (ev_drop_hit),
    .clr_line  (hit_line),
    .rd_line   (victim_line),
    .rd_tag    (victim_tag),
    .match_vec (match_vec),
    .valid_vec (valid_vec)
  );

  tagu_lru #(.LINES(LINES)) i_lru (
    .clk         (clk),
    .rst         (rst),
    .touch_mru   (touch_mru),
    .touch_lru   (ev_drop_hit),
    .touch_line  (touch_line),
    .valid_vec   (valid_vec),
    .victim_line (victim_line)
  );

  // R2: hit and miss are quiet without a lookup, exclusive with one
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_req |-> (!hit && !miss));
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> (hit != miss));

  // R6: a miss leaves valid bits and the victim unchanged
  a_r6_miss_no_change: assert property (@(posedge clk) disable iff (rst)
    miss |=> $stable(valid_vec) && $stable(victim_line) && $stable(victim_tag));

  // R9: lookup and fill never raised together
  a_r9_no_req_fill: assert property (@(posedge clk) disable iff (rst)
    !(cmd_req && cmd_fill));

  // R9: a no-operation leaves the victim alone
  a_r9_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE) |=> $stable(victim_line) && $stable(valid_vec));

endmodule

// File: tb/test_tag_unit_fa.sv
module test_tag_unit_fa;

  localparam int LINES = 4;
  localparam int AW    = 8;
  localparam int LW    = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_req, cmd_wr, cmd_inval, cmd_fill;
  logic [AW-1:0] addr;
  logic          hit, miss;
  logic [LW-1:0] hit_line, victim_line;
  logic [AW-1:0] victim_tag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tag_unit_fa #(.LINES(LINES), .AW(AW)) i_tag_unit_fa (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_wr(cmd_wr),
    .cmd_inval(cmd_inval), .cmd_fill(cmd_fill), .addr(addr),
    .hit(hit), .miss(miss), .hit_line(hit_line),
    .victim_line(victim_line), .victim_tag(victim_tag)
  );

  // reference model: last-use stamps
  int          m_stamp [LINES];
  bit          m_valid [LINES];
  logic [7:0]  m_tag   [LINES];
  int          m_hi, m_lo;

  task automatic m_reset();
    for (int i = 0; i < LINES; i++) begin
      m_stamp[i] = i; m_valid[i] = 0; m_tag[i] = '0;
    end
    m_hi = LINES - 1; m_lo = 0;
  endtask

  function automatic int m_find(input logic [7:0] a);
    for (int i = 0; i < LINES; i++)
      if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = -1;
    for (int i = 0; i < LINES; i++)
      if (!m_valid[i] && (best < 0 || m_stamp[i] < m_stamp[best])) best = i;
    if (best >= 0) return best;
    best = 0;
    for (int i = 1; i < LINES; i++)
      if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  task automatic m_step(input bit rq, input bit wr, input bit inv,
                        input bit fl, input logic [7:0] a);
    int h, v;
    h = m_find(a);
    if (rq) begin
      if (h >= 0) begin
        if (inv) begin m_valid[h] = 0; m_lo--; m_stamp[h] = m_lo; end
        else begin m_hi++; m_stamp[h] = m_hi; end
      end
    end else if (fl) begin
      v = m_victim();
      m_tag[v] = a; m_valid[v] = 1; m_hi++; m_stamp[v] = m_hi;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit rq, input bit wr, input bit inv,
                       input bit fl, input logic [7:0] a);
    cmd_req = rq; cmd_wr = wr; cmd_inval = inv; cmd_fill = fl; addr = a;
  endtask

  // {req, wr, inv, fill, addr, expected hit}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0001, 8'h10, 1'b0},  // fill line 0
    {4'b0001, 8'h21, 1'b0},  // fill line 1
    {4'b0001, 8'h32, 1'b0},  // fill line 2
    {4'b0001, 8'h43, 1'b0},  // fill line 3
    {4'b1000, 8'h21, 1'b1},  // read hit
    {4'b0001, 8'h5A, 1'b0},  // fill evicts LRU line 0
    {4'b1000, 8'h10, 1'b0},  // evicted tag misses
    {4'b1100, 8'h32, 1'b1},  // update hit
    {4'b1010, 8'h43, 1'b1},  // read and drop
    {4'b1000, 8'h43, 1'b0},  // dropped tag misses
    {4'b1110, 8'h21, 1'b1},  // write and drop
    {4'b0001, 8'h6C, 1'b0},  // fill lands on LRU invalid line
    {4'b0000, 8'h6C, 1'b0},  // nop
    {4'b1000, 8'h6C, 1'b1},  // read hit on new tag
    {4'b1010, 8'h99, 1'b0},  // drop that misses
    {4'b1000, 8'h32, 1'b1}   // read hit
  };

  task automatic sample(input bit rq, input bit exph, input logic [7:0] a);
    int mh;
    mh = m_find(a);
    chk("R2", "hit", int'(hit), int'(rq && exph));
    chk("R2", "miss", int'(miss), int'(rq && !exph));
    if (rq) chk("R3", "model hit", int'(mh >= 0), int'(exph));
    if (rq && exph) chk("R3", "hit_line", int'(hit_line), mh);
    chk("R7", "victim_line", int'(victim_line), m_victim());
    chk("R7", "victim_tag", int'(victim_tag), int'(m_tag[m_victim()]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; drive(0, 0, 0, 0, 8'h00);
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
    m_reset();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1; drive(0, 0, 0, 0, 8'h00);
    m_reset();
    do_reset();

    // R1: reset state
    #2;
    chk("R1", "victim after reset", int'(victim_line), 0);
    chk("R1", "victim_tag after reset", int'(victim_tag), 0);
    chk("R1", "hit idle", int'(hit), 0);
    chk("R1", "miss idle", int'(miss), 0);

    // table walk: R4 R5 R6 R8 R9 effects appear in the next vector's victim
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8:1]);
      #2;
      sample(VEC[k][12], VEC[k][0], VEC[k][8:1]);
      @(posedge clk);
      m_step(VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8:1]);
    end

    // R5: after a drop the dropped line is next victim
    @(negedge clk); drive(1, 0, 0, 0, 8'h5A); #2;
    chk("R5", "line of 5A", int'(hit_line), 0);
    @(posedge clk); m_step(1, 0, 0, 0, 8'h5A);
    @(negedge clk); drive(1, 0, 1, 0, 8'h5A); @(posedge clk);
    m_step(1, 0, 1, 0, 8'h5A);
    @(negedge clk); drive(0, 0, 0, 0, 8'h00); #2;
    chk("R5", "victim after drop", int'(victim_line), 0);
    chk("R5", "victim_tag after drop", int'(victim_tag), 8'h5A);

    // R6: a miss with update flag changes nothing
    @(negedge clk); drive(1, 1, 0, 0, 8'hEE); #2;
    chk("R6", "miss", int'(miss), 1);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0, 8'h00); #2;
    chk("R6", "victim unchanged", int'(victim_line), m_victim());

    // R8: fill stores address, subsequent read hits at that line
    @(negedge clk); drive(0, 0, 0, 1, 8'h77); @(posedge clk);
    m_step(0, 0, 0, 1, 8'h77);
    @(negedge clk); drive(1, 0, 0, 0, 8'h77); #2;
    chk("R8", "hit after fill", int'(hit), 1);
    chk("R8", "line after fill", int'(hit_line), 0);
    @(posedge clk); m_step(1, 0, 0, 0, 8'h77);

    // R9: nop keeps every output quiet and the victim stable
    @(negedge clk); drive(0, 0, 0, 0, 8'h77); #2;
    chk("R9", "nop hit", int'(hit), 0);
    chk("R9", "nop victim", int'(victim_line), m_victim());

    // R1: reset mid-run empties the cache
    do_reset();
    drive(1, 0, 0, 0, 8'h77); #2;
    chk("R1", "miss after reset", int'(miss), 1);
    chk("R1", "victim after second reset", int'(victim_line), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule